// File: doc/BRIEF.md
# Subvector Swizzle Move Unit

This unit performs one swizzled move on a short subvector of two, three or four lanes (a single lane also works). A 12-bit immediate holds one 3-bit selector for each destination lane. Each selector does one of three things to its lane. It can pick a source lane, write the single-precision constant zero or one, or leave the lane as it was. The selector field therefore also acts as a write mask carried in the immediate.

One transaction carries the source lanes, the current destination lanes, the subvector length, the immediate and one predicate bit that covers the whole subvector. The transaction enters through a valid/ready handshake. The unit returns the new destination lanes and a write enable for each lane. It also returns a flag that marks a selector naming a source lane outside the subvector. The result sits in one output register and stays there until the consumer takes it. Register-file access and the loop over subvectors belong to the caller.

Top module: `swz_move_unit`

## Requirements
- R1: For an active lane s (s < length), a selector value 0 to 3 that is below the length copies source lane number `selector` into lane s and sets its write enable. Lane s takes its selector from immediate bits [3s+2:3s].
- R2: Selector value 4 writes 32'h00000000 and sets the lane's write enable.
- R3: Selector value 5 writes 32'h3F800000 and sets the lane's write enable.
- R4: Selector values 6 and 7 clear the lane's write enable, and the lane output carries the old destination value.
- R5: Lanes at or beyond the length ignore their selectors. Their write enable is clear, their output is the old destination value, and they never raise the illegal flag. The length is given as `subvl_m1`, which holds length minus one (0 to 3).
- R6: On an active lane, a selector value 0 to 3 that is at or beyond the length writes zero, keeps the write enable set, and raises `out_illegal`.
- R7: A predicate of 0 clears every write enable, and every lane output then carries the old destination value. The illegal flag is still reported.
- R8: `in_ready` is high when the output register is empty or is being drained. While `out_valid` is high and `out_ready` is low, the outputs hold steady and no new input is accepted.
- R9: A transaction accepted at a clock edge shows its result with `out_valid` high right after that edge. Once the result is drained and no new input arrives, `out_valid` falls.
- R10: Synchronous active-high reset clears `out_valid`, all write enables and the illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transaction offered |
| in_ready | output | 1 | Unit can take a transaction |
| src_lanes | input | LANES*EW | Source subvector, lane 0 in the low bits |
| dst_old | input | LANES*EW | Current destination subvector |
| subvl_m1 | input | LIDX_W | Subvector length minus one |
| swz_imm | input | LANES*3 | Selector field, 3 bits per lane |
| pred | input | 1 | Subvector predicate |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_lanes | output | LANES*EW | New destination subvector |
| out_we | output | LANES | Write enable per lane |
| out_illegal | output | 1 | A selector named a lane outside the subvector |

## Verification
All results come from one register stage. The lanes, enables and illegal flag of a transaction accepted at a rising edge are due right after that edge. The bench changes inputs on falling edges and reads every output on the falling edge that follows the accepting rising edge, half a period after the register loads. For the back-pressure case it reads again one full cycle later to confirm nothing moved. It then releases the consumer and reads the new result on the next falling edge.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    SW_SRC  = 2'd0,
    SW_ZERO = 2'd1,
    SW_ONE  = 2'd2,
    SW_KEEP = 2'd3
  } swz_kind_e;

  function automatic swz_kind_e swz_classify(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0, 3'd1, 3'd2, 3'd3: swz_classify = SW_SRC;
      3'd4:                   swz_classify = SW_ZERO;
      3'd5:                   swz_classify = SW_ONE;
      default:                swz_classify = SW_KEEP;
    endcase
  endfunction
endpackage

// File: rtl/swz_lane.sv
module swz_lane
  import swz_pkg::*;
#(
  parameter int LANE    = 0,
  parameter int LANES   = 4,
  parameter int EW      = 32,
  parameter logic [EW-1:0] ONE_VAL = 32'h3F800000,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*EW-1:0] src_flat,
  input  logic [EW-1:0]       old_val,
  input  logic [SEL_W-1:0]    sel,
  input  logic [LIDX_W-1:0]   subvl_m1,
  output logic [EW-1:0]       val,
  output logic                we,
  output logic                illegal
);
  logic      active;
  logic      in_range;
  swz_kind_e kind;

  assign active   = (LIDX_W'(LANE) <= subvl_m1);
  assign in_range = (sel <= SEL_W'(subvl_m1));
  assign kind     = swz_classify(sel);

  always_comb begin
    val     = old_val;
    we      = 1'b0;
    illegal = 1'b0;
    if (active) begin
      case (kind)
        SW_SRC: begin
          we = 1'b1;
          if (in_range) begin
            val = src_flat[sel[LIDX_W-1:0]*EW +: EW];
          end else begin
            val     = '0;
            illegal = 1'b1;
          end
        end
        SW_ZERO: begin
          val = '0;
          we  = 1'b1;
        end
        SW_ONE: begin
          val = ONE_VAL;
          we  = 1'b1;
        end
        default: begin
          val = old_val;
          we  = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/swz_out_reg.sv
module swz_out_reg #(
  parameter int LANES = 4,
  parameter int EW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                drain,
  input  logic [LANES*EW-1:0] d_lanes,
  input  logic [LANES-1:0]    d_we,
  input  logic                d_illegal,
  output logic                q_valid,
  output logic [LANES*EW-1:0] q_lanes,
  output logic [LANES-1:0]    q_we,
  output logic                q_illegal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid   <= 1'b0;
      q_lanes   <= '0;
      q_we      <= '0;
      q_illegal <= 1'b0;
    end else if (load) begin
      q_valid   <= 1'b1;
      q_lanes   <= d_lanes;
      q_we      <= d_we;
      q_illegal <= d_illegal;
    end else if (drain) begin
      q_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/swz_move_unit.sv
module swz_move_unit
  import swz_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EW    = 32,
  parameter logic [EW-1:0] ONE_VAL = 32'h3F800000,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*EW-1:0]   src_lanes,
  input  logic [LANES*EW-1:0]   dst_old,
  input  logic [LIDX_W-1:0]     subvl_m1,
  input  logic [LANES*SEL_W-1:0] swz_imm,
  input  logic                  pred,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES*EW-1:0]   out_lanes,
  output logic [LANES-1:0]      out_we,
  output logic                  out_illegal
);
  logic [LANES*EW-1:0] nxt_lanes;
  logic [LANES-1:0]    nxt_we;
  logic [LANES-1:0]    lane_ill;
  logic                accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar s = 0; s < LANES; s++) begin : g_lane
    logic [EW-1:0] l_val;
    logic          l_we;
    logic          l_ill;

    swz_lane #(
      .LANE(s), .LANES(LANES), .EW(EW), .ONE_VAL(ONE_VAL)
    ) u_lane (
      .src_flat (src_lanes),
      .old_val  (dst_old[s*EW +: EW]),
      .sel      (swz_imm[s*SEL_W +: SEL_W]),
      .subvl_m1 (subvl_m1),
      .val      (l_val),
      .we       (l_we),
      .illegal  (l_ill)
    );

    assign nxt_we[s]             = l_we && pred;
    assign nxt_lanes[s*EW +: EW] = nxt_we[s] ? l_val : dst_old[s*EW +: EW];
    assign lane_ill[s]           = l_ill;
  end

  swz_out_reg #(.LANES(LANES), .EW(EW)) u_oreg (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .drain     (out_ready),
    .d_lanes   (nxt_lanes),
    .d_we      (nxt_we),
    .d_illegal (|lane_ill),
    .q_valid   (out_valid),
    .q_lanes   (out_lanes),
    .q_we      (out_we),
    .q_illegal (out_illegal)
  );
endmodule

// File: rtl/swz_move_chk.sv
module swz_move_chk #(
  parameter int LANES = 4,
  parameter int EW    = 32,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [LIDX_W-1:0]   subvl_m1,
  input logic                pred,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*EW-1:0] out_lanes,
  input logic [LANES-1:0]    out_we
);
  logic [LANES-1:0] tail_q;
  logic [LANES-1:0] tail_d;

  always_comb begin
    for (int s = 0; s < LANES; s++) tail_d[s] = (s > int'(subvl_m1));
  end

  always_ff @(posedge clk) begin
    if (rst) tail_q <= '0;
    else if (in_valid && in_ready) tail_q <= tail_d;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_lanes) && $stable(out_we));

  p_block_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_pred_off_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !pred |=> out_we == '0);

  p_tail_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> (out_we & tail_q) == '0);
endmodule

bind swz_move_unit swz_move_chk #(.LANES(LANES), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .subvl_m1(subvl_m1), .pred(pred), .out_valid(out_valid),
  .out_ready(out_ready), .out_lanes(out_lanes), .out_we(out_we)
);

// File: tb/sim_swz_move_unit.sv
`timescale 1ns/1ps
module sim_swz_move_unit;
  localparam int LANES = 4;
  localparam int EW    = 32;
  localparam logic [31:0] SRC_BASE = 32'hA000_0000;
  localparam logic [31:0] OLD_BASE = 32'hD000_0000;
  localparam int NV = 8;
  // entry: {subvl_m1[2], s3,s2,s1,s0 [12], pred, we[4], ill, c3,c2,c1,c0 [12]}
  // lane code: 0-3 source lane, 4 zero, 5 one, 6 old value
  localparam logic [31:0] VEC [NV] = '{
    {2'd3, 3'd0,3'd1,3'd2,3'd3, 1'b1, 4'b1111, 1'b0, 3'd0,3'd1,3'd2,3'd3}, // R1
    {2'd3, 3'd7,3'd6,3'd5,3'd4, 1'b1, 4'b0011, 1'b0, 3'd6,3'd6,3'd5,3'd4}, // R2 R3 R4
    {2'd1, 3'd5,3'd0,3'd0,3'd1, 1'b1, 4'b0011, 1'b0, 3'd6,3'd6,3'd0,3'd1}, // R5
    {2'd1, 3'd1,3'd1,3'd0,3'd3, 1'b1, 4'b0011, 1'b1, 3'd6,3'd6,3'd0,3'd4}, // R6
    {2'd3, 3'd3,3'd2,3'd1,3'd0, 1'b0, 4'b0000, 1'b0, 3'd6,3'd6,3'd6,3'd6}, // R7
    {2'd2, 3'd0,3'd5,3'd3,3'd2, 1'b1, 4'b0111, 1'b1, 3'd6,3'd5,3'd4,3'd2}, // R6 R5
    {2'd0, 3'd3,3'd5,3'd4,3'd0, 1'b1, 4'b0001, 1'b0, 3'd6,3'd6,3'd6,3'd0}, // R5
    {2'd0, 3'd0,3'd0,3'd0,3'd1, 1'b0, 4'b0000, 1'b1, 3'd6,3'd6,3'd6,3'd6}  // R7
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready, pred = 1'b0, out_valid, out_ready = 1'b1, out_illegal;
  logic [LANES*EW-1:0] src_lanes, dst_old, out_lanes;
  logic [1:0] subvl_m1 = '0;
  logic [11:0] swz_imm = '0;
  logic [LANES-1:0] out_we;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  swz_move_unit #(.LANES(LANES), .EW(EW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_lanes(src_lanes), .dst_old(dst_old), .subvl_m1(subvl_m1),
    .swz_imm(swz_imm), .pred(pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_lanes(out_lanes), .out_we(out_we),
    .out_illegal(out_illegal)
  );

  function automatic logic [LANES*EW-1:0] expect_lanes(input logic [11:0] codes);
    logic [LANES*EW-1:0] r;
    for (int s = 0; s < LANES; s++) begin
      case (codes[3*s +: 3])
        3'd4:    r[s*EW +: EW] = 32'h0000_0000;
        3'd5:    r[s*EW +: EW] = 32'h3F80_0000;
        3'd6:    r[s*EW +: EW] = OLD_BASE + 32'(s);
        default: r[s*EW +: EW] = SRC_BASE + 32'(codes[3*s +: 3]);
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] v);
    subvl_m1 = v[31:30];
    swz_imm  = v[29:18];
    pred     = v[17];
    in_valid = 1'b1;
  endtask

  initial begin
    for (int s = 0; s < LANES; s++) begin
      src_lanes[s*EW +: EW] = SRC_BASE + 32'(s);
      dst_old[s*EW +: EW]   = OLD_BASE + 32'(s);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 out_valid", 128'(out_valid), 128'(0));
    check("R10 out_we", 128'(out_we), 128'(0));
    check("R10 out_illegal", 128'(out_illegal), 128'(0));
    check("R8 in_ready empty", 128'(in_ready), 128'(1));

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R9 valid vec%0d", i), 128'(out_valid), 128'(1));
      check($sformatf("R1-R7 we vec%0d", i), 128'(out_we), 128'(VEC[i][16:13]));
      check($sformatf("R6 illegal vec%0d", i), 128'(out_illegal), 128'(VEC[i][12]));
      check($sformatf("R1-R7 lanes vec%0d", i), out_lanes, expect_lanes(VEC[i][11:0]));
    end

    // R8 back-pressure: last result is VEC[7]; offer VEC[0] while stalled
    out_ready = 1'b0;
    drive(VEC[0]);
    #0.1;
    check("R8 in_ready stalled", 128'(in_ready), 128'(0));
    @(posedge clk);
    @(negedge clk);
    check("R8 held lanes", out_lanes, expect_lanes(VEC[7][11:0]));
    check("R8 held valid", 128'(out_valid), 128'(1));
    check("R8 held illegal", 128'(out_illegal), 128'(1));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 accepted after stall", out_lanes, expect_lanes(VEC[0][11:0]));
    check("R8 we after stall", 128'(out_we), 128'(VEC[0][16:13]));
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 drained", 128'(out_valid), 128'(0));

    // R10 reset while holding a result
    drive(VEC[1]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset clears valid", 128'(out_valid), 128'(0));
    check("R10 reset clears we", 128'(out_we), 128'(0));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule